// File: doc/BRIEF.md
# Quadrant ROM/RAM bank mapper

This block sits between a processor's 64 KB logical address space and a set of external ROM and RAM chips. The space is cut into four 16 KB quadrants. The two lower quadrants go to ROM and the two upper quadrants go to RAM. In each half, the first quadrant is pinned to physical page 0. The second quadrant is a window whose page number comes from a small bank register. There is a 3-bit register for ROM and a 4-bit register for RAM.

The block drives one shared set of upper physical address lines. These lines carry zeros for a pinned quadrant, and otherwise the ROM or RAM bank number, according to the top address bit. All memory chips can therefore be wired to the same lines. The block also drives two active-low chip selects.

A chip select is asserted only for a memory cycle whose status marks a privileged access or a macro-store access. Macro-store code and system code share the same ROM select. The processor loads the bank registers through a decoded I/O write strobe.

Top module: `quadrant_bank_mapper`

## Requirements
- R1: After reset both bank registers hold 0, so the banked quadrants at 0x4000 and 0xC000 show page 0 on `page_hi`.
- R2: A qualified access to 0x0000–0x3FFF drives `rom_cs_n` low, `ram_cs_n` high and `page_hi` = 0.
- R3: A qualified access to 0x4000–0x7FFF drives `rom_cs_n` low and `page_hi` = the ROM bank, zero-extended.
- R4: A qualified access to 0x8000–0xBFFF drives `ram_cs_n` low, `rom_cs_n` high and `page_hi` = 0.
- R5: A qualified access to 0xC000–0xFFFF drives `ram_cs_n` low and `page_hi` = the RAM bank.
- R6: A clock edge with `bank_wr` = 1 loads `bank_wr_data[2:0]` into the ROM bank when `bank_wr_sel` = 0, and `bank_wr_data[3:0]` into the RAM bank when `bank_wr_sel` = 1. Higher data bits are ignored, the other register keeps its value, and the new page shows from the next cycle on.
- R7: Both chip selects stay high unless `mem_cycle` = 1 and either `bus_st` = 2'b01, or `priv_sel` = 1 with `bus_st` being 2'b00 (normal) or 2'b10 (interrupt vector fetch). A `bus_st` of 2'b11 never selects memory.
- R8: A macro-store access (`bus_st` = 2'b01) is qualified without `priv_sel`. It uses the same ROM and RAM selects as a privileged access.
- R9: An interrupt vector fetch (`bus_st` = 2'b10) from the pinned quadrant maps to page 0 whatever the banks hold. Such cycles leave both bank registers unchanged.
- R10: `rom_cs_n` and `ram_cs_n` are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, clears both bank registers |
| cpu_addr | input | 16 | Processor logical byte address |
| priv_sel | input | 1 | High for a privileged (supervisor) access |
| mem_cycle | input | 1 | High during a memory cycle |
| bus_st | input | 2 | Bus status: 00 normal, 01 macro-store, 10 vector fetch, 11 non-memory |
| bank_wr | input | 1 | Decoded I/O write strobe for the bank registers |
| bank_wr_sel | input | 1 | 0 selects the ROM bank register, 1 selects the RAM bank register |
| bank_wr_data | input | 16 | Write data; only the low bits are used |
| rom_cs_n | output | 1 | Active-low ROM chip select |
| ram_cs_n | output | 1 | Active-low RAM chip select |
| page_hi | output | 4 | Shared upper physical address lines |

## Verification
A wrong bank register shows on `page_hi` during any access to a banked quadrant. It shows in the cycle right after the faulty write, and it stays there until the next write. A wrong qualifier shows at once as a chip select going low when it should not, or staying high when it should go low. A wrong quadrant decode shows at once as the wrong select or a nonzero page in a pinned quadrant. The checks therefore look at the outputs combinationally, within the same cycle as each address, and at the page one cycle after each register write.

// File: rtl/qbm_pkg.sv
package qbm_pkg;

  typedef enum logic [1:0] {
    ST_NORMAL = 2'b00,
    ST_MACRO  = 2'b01,
    ST_VECTOR = 2'b10,
    ST_OTHER  = 2'b11
  } bus_status_e;

  // Privileged memory access or macro-store access reaches this memory.
  function automatic logic access_ok(input logic priv, input logic mem,
                                     input logic [1:0] st);
    logic macro_hit;
    logic priv_hit;
    macro_hit = (st == ST_MACRO);
    priv_hit  = priv && ((st == ST_NORMAL) || (st == ST_VECTOR));
    return mem && (macro_hit || priv_hit);
  endfunction

  function automatic int unsigned max_w(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/qbm_bank_regs.sv
module qbm_bank_regs #(
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned ROM_BANK_W = 3,
  parameter int unsigned RAM_BANK_W = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic                  wr_sel,
  input  logic [DATA_W-1:0]     wr_data,
  output logic [ROM_BANK_W-1:0] rom_bank,
  output logic [RAM_BANK_W-1:0] ram_bank
);

  logic rom_load;
  logic ram_load;

  assign rom_load = wr_en && !wr_sel;
  assign ram_load = wr_en &&  wr_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rom_bank <= '0;
    end else if (rom_load) begin
      rom_bank <= wr_data[ROM_BANK_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ram_bank <= '0;
    end else if (ram_load) begin
      ram_bank <= wr_data[RAM_BANK_W-1:0];
    end
  end

  // R6: a strobe loads the chosen register with the low data bits
  assert_rom_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_sel) |=> (rom_bank == $past(wr_data[ROM_BANK_W-1:0])));
  assert_ram_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel) |=> (ram_bank == $past(wr_data[RAM_BANK_W-1:0])));

  // R9: with no strobe (interrupt entry included) the registers hold
  assert_rom_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && !wr_sel) |=> $stable(rom_bank));
  assert_ram_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_sel) |=> $stable(ram_bank));

endmodule

// File: rtl/qbm_access_qual.sv
module qbm_access_qual
  import qbm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       priv_sel,
  input  logic       mem_cycle,
  input  logic [1:0] bus_st,
  output logic       mem_sel
);

  always_comb begin
    mem_sel = access_ok(priv_sel, mem_cycle, bus_st);
  end

  // R7: no selection outside a memory cycle or on a non-memory status
  assert_sel_needs_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_sel |-> (mem_cycle && (bus_st != ST_OTHER)));

  // R8: macro-store cycles are always admitted
  assert_macro_admitted_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_cycle && (bus_st == ST_MACRO)) |-> mem_sel);

endmodule

// File: rtl/qbm_quadrant_dec.sv
module qbm_quadrant_dec #(
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned ROM_BANK_W = 3,
  parameter int unsigned RAM_BANK_W = 4,
  parameter int unsigned PAGE_W     = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ADDR_W-1:0]     addr,
  input  logic                  mem_sel,
  input  logic [ROM_BANK_W-1:0] rom_bank,
  input  logic [RAM_BANK_W-1:0] ram_bank,
  output logic                  rom_cs_n,
  output logic                  ram_cs_n,
  output logic [PAGE_W-1:0]     page_hi
);

  localparam int unsigned HALF_BIT = ADDR_W - 1;
  localparam int unsigned WIN_BIT  = ADDR_W - 2;

  logic half_ram;
  logic banked;

  assign half_ram = addr[HALF_BIT];
  assign banked   = addr[WIN_BIT];

  logic unused_addr_lo;
  assign unused_addr_lo = ^addr[WIN_BIT-1:0];

  always_comb begin
    rom_cs_n = !(mem_sel && !half_ram);
    ram_cs_n = !(mem_sel &&  half_ram);
  end

  always_comb begin
    if (!banked) begin
      page_hi = '0;
    end else if (half_ram) begin
      page_hi = PAGE_W'(ram_bank);
    end else begin
      page_hi = PAGE_W'(rom_bank);
    end
  end

  // R10: the two selects exclude each other
  assert_cs_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rom_cs_n && !ram_cs_n));

  // R2 / R4: pinned quadrants always present page 0
  assert_fixed_page_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((!rom_cs_n || !ram_cs_n) && !banked) |-> (page_hi == '0));

endmodule

// File: rtl/quadrant_bank_mapper.sv
module quadrant_bank_mapper #(
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned ROM_BANK_W = 3,
  parameter int unsigned RAM_BANK_W = 4,
  localparam int unsigned PAGE_W    = qbm_pkg::max_w(ROM_BANK_W, RAM_BANK_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              priv_sel,
  input  logic              mem_cycle,
  input  logic [1:0]        bus_st,
  input  logic              bank_wr,
  input  logic              bank_wr_sel,
  input  logic [DATA_W-1:0] bank_wr_data,
  output logic              rom_cs_n,
  output logic              ram_cs_n,
  output logic [PAGE_W-1:0] page_hi
);

  logic [ROM_BANK_W-1:0] rom_bank_q;
  logic [RAM_BANK_W-1:0] ram_bank_q;
  logic                  mem_sel;

  qbm_bank_regs #(
    .DATA_W    (DATA_W),
    .ROM_BANK_W(ROM_BANK_W),
    .RAM_BANK_W(RAM_BANK_W)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (bank_wr),
    .wr_sel  (bank_wr_sel),
    .wr_data (bank_wr_data),
    .rom_bank(rom_bank_q),
    .ram_bank(ram_bank_q)
  );

  qbm_access_qual u_qual (
    .clk      (clk),
    .rst_n    (rst_n),
    .priv_sel (priv_sel),
    .mem_cycle(mem_cycle),
    .bus_st   (bus_st),
    .mem_sel  (mem_sel)
  );

  qbm_quadrant_dec #(
    .ADDR_W    (ADDR_W),
    .ROM_BANK_W(ROM_BANK_W),
    .RAM_BANK_W(RAM_BANK_W),
    .PAGE_W    (PAGE_W)
  ) u_dec (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (cpu_addr),
    .mem_sel (mem_sel),
    .rom_bank(rom_bank_q),
    .ram_bank(ram_bank_q),
    .rom_cs_n(rom_cs_n),
    .ram_cs_n(ram_cs_n),
    .page_hi (page_hi)
  );

  // R3: banked ROM window shows the ROM register
  assert_rom_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!rom_cs_n && cpu_addr[ADDR_W-2]) |-> (page_hi == PAGE_W'(rom_bank_q)));

  // R5: banked RAM window shows the RAM register
  assert_ram_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ram_cs_n && cpu_addr[ADDR_W-2]) |-> (page_hi == PAGE_W'(ram_bank_q)));

endmodule

// File: tb/test_quadrant_bank_mapper.sv
module test_quadrant_bank_mapper;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic        priv_sel = 1'b0;
  logic        mem_cycle = 1'b0;
  logic [1:0]  bus_st = 2'b11;
  logic        bank_wr = 1'b0;
  logic        bank_wr_sel = 1'b0;
  logic [15:0] bank_wr_data = '0;
  logic        rom_cs_n;
  logic        ram_cs_n;
  logic [3:0]  page_hi;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  quadrant_bank_mapper i_quadrant_bank_mapper (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .priv_sel(priv_sel),
    .mem_cycle(mem_cycle), .bus_st(bus_st), .bank_wr(bank_wr),
    .bank_wr_sel(bank_wr_sel), .bank_wr_data(bank_wr_data),
    .rom_cs_n(rom_cs_n), .ram_cs_n(ram_cs_n), .page_hi(page_hi)
  );

  // {addr[16], priv, mem, st[2], rom_n, ram_n, page[4], req[4]}; banks ROM=5, RAM=11
  localparam int NV = 14;
  localparam logic [29:0] VEC [NV] = '{
    {16'h0000, 1'b1, 1'b1, 2'b00, 1'b0, 1'b1, 4'h0, 4'd2},  // R2
    {16'h3FFF, 1'b1, 1'b1, 2'b00, 1'b0, 1'b1, 4'h0, 4'd2},  // R2
    {16'h4000, 1'b1, 1'b1, 2'b00, 1'b0, 1'b1, 4'h5, 4'd3},  // R3
    {16'h7FFE, 1'b1, 1'b1, 2'b00, 1'b0, 1'b1, 4'h5, 4'd3},  // R3
    {16'h8000, 1'b1, 1'b1, 2'b00, 1'b1, 1'b0, 4'h0, 4'd4},  // R4
    {16'hBFFF, 1'b1, 1'b1, 2'b00, 1'b1, 1'b0, 4'h0, 4'd4},  // R4
    {16'hC000, 1'b1, 1'b1, 2'b00, 1'b1, 1'b0, 4'hB, 4'd5},  // R5
    {16'hFFFF, 1'b1, 1'b1, 2'b00, 1'b1, 1'b0, 4'hB, 4'd5},  // R5
    {16'h4000, 1'b0, 1'b1, 2'b01, 1'b0, 1'b1, 4'h5, 4'd8},  // R8 macro ROM
    {16'hC100, 1'b0, 1'b1, 2'b01, 1'b1, 1'b0, 4'hB, 4'd8},  // R8 macro RAM
    {16'h1234, 1'b0, 1'b1, 2'b00, 1'b1, 1'b1, 4'h0, 4'd7},  // R7 user access
    {16'hC000, 1'b1, 1'b0, 2'b00, 1'b1, 1'b1, 4'hB, 4'd7},  // R7 no cycle
    {16'hC000, 1'b1, 1'b1, 2'b11, 1'b1, 1'b1, 4'hB, 4'd7},  // R7 non-memory
    {16'h0000, 1'b1, 1'b1, 2'b10, 1'b0, 1'b1, 4'h0, 4'd9}   // R9 vector fetch
  };

  task automatic chk(input string tag, input logic [5:0] got, input logic [5:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got {rom_n,ram_n,page}=%b expected %b", tag, got, exp);
    end
  endtask

  task automatic drive(input logic [15:0] a, input logic p, input logic m,
                       input logic [1:0] s);
    @(negedge clk);
    cpu_addr = a; priv_sel = p; mem_cycle = m; bus_st = s;
    #1;
  endtask

  task automatic write_bank(input logic sel, input logic [15:0] d);
    @(negedge clk);
    bank_wr = 1'b1; bank_wr_sel = sel; bank_wr_data = d;
    @(negedge clk);
    bank_wr = 1'b0; bank_wr_data = '0;
  endtask

  initial begin
    #(5ns * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: reset leaves both banked windows at page 0
    drive(16'h4000, 1'b1, 1'b1, 2'b00);
    chk("R1 rom window", {rom_cs_n, ram_cs_n, page_hi}, {1'b0, 1'b1, 4'h0});
    drive(16'hC000, 1'b1, 1'b1, 2'b00);
    chk("R1 ram window", {rom_cs_n, ram_cs_n, page_hi}, {1'b1, 1'b0, 4'h0});

    write_bank(1'b0, 16'h0005);
    write_bank(1'b1, 16'h000B);

    for (int i = 0; i < NV; i++) begin
      logic [29:0] v;
      v = VEC[i];
      drive(v[29:14], v[13], v[12], v[11:10]);
      chk($sformatf("R%0d vector %0d", v[3:0], i),
          {rom_cs_n, ram_cs_n, page_hi}, v[9:4]);
    end

    // R6: upper data bits ignored, other register untouched
    write_bank(1'b0, 16'hFFF2);
    drive(16'h5000, 1'b1, 1'b1, 2'b00);
    chk("R6 rom low bits", {rom_cs_n, ram_cs_n, page_hi}, {1'b0, 1'b1, 4'h2});
    drive(16'hD000, 1'b1, 1'b1, 2'b00);
    chk("R6 ram kept", {rom_cs_n, ram_cs_n, page_hi}, {1'b1, 1'b0, 4'hB});
    write_bank(1'b1, 16'hABC6);
    drive(16'hD000, 1'b1, 1'b1, 2'b00);
    chk("R6 ram low bits", {rom_cs_n, ram_cs_n, page_hi}, {1'b1, 1'b0, 4'h6});
    drive(16'h5000, 1'b1, 1'b1, 2'b00);
    chk("R6 rom kept", {rom_cs_n, ram_cs_n, page_hi}, {1'b0, 1'b1, 4'h2});

    // R6: page visible the cycle right after the strobe edge
    @(negedge clk);
    cpu_addr = 16'h4000; priv_sel = 1'b1; mem_cycle = 1'b1; bus_st = 2'b00;
    bank_wr = 1'b1; bank_wr_sel = 1'b0; bank_wr_data = 16'h0007;
    #1;
    chk("R6 before edge", {rom_cs_n, ram_cs_n, page_hi}, {1'b0, 1'b1, 4'h2});
    @(negedge clk);
    bank_wr = 1'b0;
    #1;
    chk("R6 after edge", {rom_cs_n, ram_cs_n, page_hi}, {1'b0, 1'b1, 4'h7});

    // R9: several vector-fetch cycles leave the banks alone
    for (int k = 0; k < 4; k++) begin
      drive(16'(k * 2), 1'b1, 1'b1, 2'b10);
      chk("R9 vector page 0", {rom_cs_n, ram_cs_n, page_hi}, {1'b0, 1'b1, 4'h0});
    end
    drive(16'h4000, 1'b1, 1'b1, 2'b00);
    chk("R9 rom bank kept", {rom_cs_n, ram_cs_n, page_hi}, {1'b0, 1'b1, 4'h7});
    drive(16'hC000, 1'b1, 1'b1, 2'b00);
    chk("R9 ram bank kept", {rom_cs_n, ram_cs_n, page_hi}, {1'b1, 1'b0, 4'h6});

    // R10: sweep the space, selects never low together
    for (int a = 0; a < 65536; a += 4096) begin
      drive(16'(a), 1'b1, 1'b1, 2'b00);
      chk("R10 exclusive", {4'b0, rom_cs_n | ram_cs_n, 1'b1}, 6'b000011);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule